// File: doc/BRIEF.md
# Windowed Command and Interrupt Controller

This block sits behind the host-facing command/status port of a network adapter. A host write to the port delivers a 16-bit command word. The 5-bit opcode sits in the top bits and an 11-bit argument sits below it. The block uses these commands to choose the active register window, acknowledge interrupt causes, load two masks, raise a software interrupt, set the receive address filter, or start a global reset. A read of the same port returns a composite status word. It is formed from the window number, a busy flag and the latched cause bits, after the visibility mask is applied.

Seven cause events arrive from the rest of the adapter as single-cycle pulses. Each pulse sets a sticky bit. When any cause bit whose interrupt-enable bit is set is present, a summary latch is set, and that latch drives the interrupt request line. The host clears causes selectively with a bitmap, so it can acknowledge a single event without losing others that arrived meanwhile.

Top module: `hcmd_ctrl`

## Requirements
- R1: A command word is decoded as opcode = bits 15..11 and argument = bits 10..0. Opcodes not listed in these requirements (for example 0x05) change no state.
- R2: Opcode 0x01 loads argument bits 2..0 into the active window. The window appears on `window_o` and in status bits 15..13. Upper argument bits are ignored.
- R3: A pulse on `ev_pulse[k]` sets cause bit k+1. The status bits are: bit 1 adapter failure, bit 2 transmit complete, bit 3 transmit available, bit 4 receive complete, bit 5 receive early, bit 6 interrupt requested, bit 7 statistics update. A set bit stays set until it is acknowledged or reset.
- R4: Opcode 0x0D (word 0x6800) clears each cause bit whose argument bit (7..0) is 1, and leaves all others. If a pulse for a bit arrives in the same cycle as its acknowledge, the bit stays set.
- R5: Status bit 0 (summary latch) is set one cycle after any cause bit 7..1 is set together with its interrupt-enable bit. It is cleared only by an acknowledge with argument bit 0 set while no enabled cause remains. `irq_o` is high exactly while the latch is set.
- R6: Opcode 0x0E loads argument bits 7..0 as the interrupt-enable mask.
- R7: Opcode 0x0F loads argument bits 7..0 as the visibility mask. Status bit i (7..0) reads as its latched value only when mask bit i is 1. A hidden bit is kept and reappears when it is unmasked.
- R8: Opcode 0x0C sets cause bit 6 (interrupt requested).
- R9: Opcode 0x10 loads argument bits 3..0 onto `rx_filter_o`: bit 0 accept own address, bit 1 accept multicast, bit 2 accept broadcast, bit 3 accept all.
- R10: Opcode 0x00 clears all causes, the latch, both masks and the filter, and sets the window to 0. It raises status bit 12 for `BUSY_CYC` cycles, and commands written while bit 12 is high are ignored.
- R11: After reset, all outputs are 0. Status bits 11..8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command port |
| wr_data | input | 16 | Command word |
| ev_pulse | input | 7 | Cause event pulses; bit k sets status bit k+1 |
| status_o | output | 16 | Composite status word |
| irq_o | output | 1 | Interrupt request |
| window_o | output | 3 | Active register window |
| rx_filter_o | output | 4 | Receive address filter |

## Verification
The hardest case to reach is the race between an acknowledge and a new pulse of the same cause in one clock cycle. The bench lines these up by driving `ev_pulse` and the acknowledge write on the same falling edge. A second such case is an acknowledge of the summary latch while an enabled cause is still set. The bench reaches it by acknowledging bit 0 before the underlying cause is cleared, and then checks that `irq_o` stays high. The busy window after a global reset is probed by writing a window select during it and confirming afterwards that the window is still 0.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int OPC_W  = 5;
  localparam int ARG_W  = 11;
  localparam int WORD_W = OPC_W + ARG_W;

  localparam logic [OPC_W-1:0] OP_GRST   = 5'h00;
  localparam logic [OPC_W-1:0] OP_WINDOW = 5'h01;
  localparam logic [OPC_W-1:0] OP_REQINT = 5'h0C;
  localparam logic [OPC_W-1:0] OP_ACK    = 5'h0D;
  localparam logic [OPC_W-1:0] OP_IMASK  = 5'h0E;
  localparam logic [OPC_W-1:0] OP_VMASK  = 5'h0F;
  localparam logic [OPC_W-1:0] OP_FILTER = 5'h10;

  typedef struct packed {
    logic grst;
    logic win;
    logic reqint;
    logic ack;
    logic imask;
    logic vmask;
    logic filt;
  } cmd_t;
endpackage

// File: rtl/hcc_decode.sv
module hcc_decode
  import hcc_pkg::*;
(
  input  logic              wr_en,
  input  logic              busy,
  input  logic [OPC_W-1:0]  opcode,
  output cmd_t              cmd
);
  logic take;
  assign take = wr_en && !busy;

  always_comb begin
    cmd = '0;
    if (take) begin
      case (opcode)
        OP_GRST:   cmd.grst   = 1'b1;
        OP_WINDOW: cmd.win    = 1'b1;
        OP_REQINT: cmd.reqint = 1'b1;
        OP_ACK:    cmd.ack    = 1'b1;
        OP_IMASK:  cmd.imask  = 1'b1;
        OP_VMASK:  cmd.vmask  = 1'b1;
        OP_FILTER: cmd.filt   = 1'b1;
        default:   cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/hcc_cause_bank.sv
module hcc_cause_bank #(
  parameter int NCAUSE  = 8,
  parameter int REQ_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NCAUSE-1:1] ev,
  input  logic              req_set,
  input  logic              ack_en,
  input  logic [NCAUSE-1:0] ack_mask,
  input  logic [NCAUSE-1:0] imask,
  output logic [NCAUSE-1:1] cause_q,
  output logic              latch_q
);
  genvar i;
  generate
    for (i = 1; i < NCAUSE; i++) begin : g_cause
      logic set_i;
      assign set_i = ev[i] | ((i == REQ_BIT) ? req_set : 1'b0);
      always_ff @(posedge clk) begin
        if (rst || clr)                 cause_q[i] <= 1'b0;
        else if (set_i)                 cause_q[i] <= 1'b1;
        else if (ack_en && ack_mask[i]) cause_q[i] <= 1'b0;
      end
    end
  endgenerate

  logic any_en;
  assign any_en = |(cause_q & imask[NCAUSE-1:1]);

  always_ff @(posedge clk) begin
    if (rst || clr)                  latch_q <= 1'b0;
    else if (any_en)                 latch_q <= 1'b1;
    else if (ack_en && ack_mask[0])  latch_q <= 1'b0;
  end
endmodule

// File: rtl/hcc_busy_timer.sv
module hcc_busy_timer #(
  parameter int BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (start)           cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/hcmd_ctrl.sv
module hcmd_ctrl
  import hcc_pkg::*;
#(
  parameter int NCAUSE   = 8,
  parameter int WIN_W    = 3,
  parameter int FILT_W   = 4,
  parameter int BUSY_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NCAUSE-2:0] ev_pulse,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o,
  output logic [WIN_W-1:0]  window_o,
  output logic [FILT_W-1:0] rx_filter_o
);
  localparam int PAD_W   = WORD_W - WIN_W - 1 - NCAUSE;
  localparam int REQ_BIT = 6;

  logic [OPC_W-1:0] opcode;
  logic [ARG_W-1:0] arg;
  assign opcode = wr_data[WORD_W-1:ARG_W];
  assign arg    = wr_data[ARG_W-1:0];

  logic busy;
  cmd_t cmd;

  hcc_decode u_dec (
    .wr_en  (wr_en),
    .busy   (busy),
    .opcode (opcode),
    .cmd    (cmd)
  );

  hcc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (cmd.grst),
    .busy  (busy)
  );

  logic [NCAUSE-1:0] imask_q, vmask_q;
  logic [NCAUSE-1:1] cause_q;
  logic              latch_q;

  hcc_cause_bank #(.NCAUSE(NCAUSE), .REQ_BIT(REQ_BIT)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clr      (cmd.grst),
    .ev       (ev_pulse),
    .req_set  (cmd.reqint),
    .ack_en   (cmd.ack),
    .ack_mask (arg[NCAUSE-1:0]),
    .imask    (imask_q),
    .cause_q  (cause_q),
    .latch_q  (latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst || cmd.grst) begin
      window_o    <= '0;
      imask_q     <= '0;
      vmask_q     <= '0;
      rx_filter_o <= '0;
    end else begin
      if (cmd.win)   window_o    <= arg[WIN_W-1:0];
      if (cmd.imask) imask_q     <= arg[NCAUSE-1:0];
      if (cmd.vmask) vmask_q     <= arg[NCAUSE-1:0];
      if (cmd.filt)  rx_filter_o <= arg[FILT_W-1:0];
    end
  end

  assign status_o = {window_o, busy, {PAD_W{1'b0}}, ({cause_q, latch_q} & vmask_q)};
  assign irq_o    = latch_q;
endmodule

// File: rtl/hcmd_ctrl_chk.sv
module hcmd_ctrl_chk #(
  parameter int NCAUSE = 8,
  parameter int WIN_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic [NCAUSE-2:0] ev_pulse,
  input logic              irq_o,
  input logic [WIN_W-1:0]  window_o,
  input logic [15:0]       status_o,
  input logic [NCAUSE-1:1] cause_q,
  input logic [NCAUSE-1:0] imask_q
);
  logic busy_s;
  logic is_grst;
  assign busy_s  = status_o[12];
  assign is_grst = wr_en && (wr_data[15:11] == 5'h00);

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
    ((|ev_pulse) && !(is_grst && !busy_s)) |=> ((cause_q & $past(ev_pulse)) == $past(ev_pulse))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_s && wr_data[15:11] == 5'h0D)
      |=> ((cause_q & $past(wr_data[NCAUSE-1:1] & ~ev_pulse)) == '0)); // R4

  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_s && wr_data[15:11] == 5'h01) |=> (window_o == $past(wr_data[WIN_W-1:0]))); // R2

  AST_GRST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (is_grst && !busy_s) |=> (status_o[12] && window_o == '0 && cause_q == '0)); // R10

  AST_BUSY_HOLDS_WIN: assert property (@(posedge clk) disable iff (rst)
    (busy_s && wr_en) |=> $stable(window_o)); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(cause_q & imask_q[NCAUSE-1:1]) != '0)); // R5
endmodule

bind hcmd_ctrl hcmd_ctrl_chk #(.NCAUSE(NCAUSE), .WIN_W(WIN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ev_pulse (ev_pulse),
  .irq_o    (irq_o),
  .window_o (window_o),
  .status_o (status_o),
  .cause_q  (cause_q),
  .imask_q  (imask_q)
);

// File: tb/sim_hcmd_ctrl.sv
`timescale 1ns/1ps
module sim_hcmd_ctrl;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [6:0]  ev_pulse = '0;
  logic [15:0] status_o;
  logic        irq_o;
  logic [2:0]  window_o;
  logic [3:0]  rx_filter_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  hcmd_ctrl #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ev_pulse(ev_pulse),
    .status_o(status_o), .irq_o(irq_o), .window_o(window_o), .rx_filter_o(rx_filter_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] op, input logic [10:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {op, a};
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    ev_pulse = p;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 status", status_o, 16'h0000);
    chk("R11 irq", {15'b0, irq_o}, 16'h0);
    chk("R11 window", {13'b0, window_o}, 16'h0);
    chk("R11 filter", {12'b0, rx_filter_o}, 16'h0);
  endtask

  task automatic t_window;
    cmd(5'h01, 11'h005);
    chk("R2 window_o", {13'b0, window_o}, 16'h5);
    chk("R2 status win", {13'b0, status_o[15:13]}, 16'h5);
    cmd(5'h01, 11'h7FA);
    chk("R2 upper arg ignored", {13'b0, window_o}, 16'h2);
  endtask

  task automatic t_unknown;
    cmd(5'h05, 11'h7FF);
    chk("R1 unknown op status", status_o, 16'h4000);
    chk("R1 unknown op filter", {12'b0, rx_filter_o}, 16'h0);
  endtask

  task automatic t_cause_vis;
    cmd(5'h0F, 11'h0FF);
    pulse(7'b0001000);                 // receive complete -> bit 4
    idle(1);
    chk("R3 bit4 set", {8'b0, status_o[7:0]}, 16'h0010);
    chk("R5 masked no irq", {15'b0, irq_o}, 16'h0);
    cmd(5'h0F, 11'h000);
    chk("R7 hidden", {8'b0, status_o[7:0]}, 16'h0000);
    cmd(5'h0F, 11'h0FF);
    chk("R7 reappears", {8'b0, status_o[7:0]}, 16'h0010);
    chk("R11 bits 11..8 zero", {12'b0, status_o[11:8]}, 16'h0);
  endtask

  task automatic t_irq;
    cmd(5'h0E, 11'h010);               // R6 enable bit 4
    idle(1);
    chk("R6/R5 irq after enable", {15'b0, irq_o}, 16'h1);
    chk("R5 latch bit0", {8'b0, status_o[7:0]}, 16'h0011);
    cmd(5'h0D, 11'h001);               // ack latch while cause remains
    idle(1);
    chk("R5 latch held by cause", {15'b0, irq_o}, 16'h1);
    cmd(5'h0D, 11'h010);
    chk("R4 bit4 cleared, latch kept", {8'b0, status_o[7:0]}, 16'h0001);
    cmd(5'h0D, 11'h001);
    chk("R5 irq cleared", {15'b0, irq_o}, 16'h0);
    chk("R5 status after clear", {8'b0, status_o[7:0]}, 16'h0000);
  endtask

  task automatic t_race;
    pulse(7'b0000010);                 // transmit complete -> bit 2
    pulse(7'b1000000);                 // statistics -> bit 7
    chk("R3 bits 2 and 7", {8'b0, status_o[7:0]}, 16'h0084);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {5'h0D, 11'h084};
    ev_pulse = 7'b0000010;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_pulse = '0;
    chk("R4 pulse wins over ack", {8'b0, status_o[7:0]}, 16'h0004);
    cmd(5'h0C, 11'h000);
    chk("R8 request bit6", {8'b0, status_o[7:0]}, 16'h0044);
  endtask

  task automatic t_filter;
    cmd(5'h10, 11'h00B);
    chk("R9 filter 0xB", {12'b0, rx_filter_o}, 16'hB);
    cmd(5'h10, 11'h7F4);
    chk("R9 filter upper ignored", {12'b0, rx_filter_o}, 16'h4);
  endtask

  task automatic t_grst;
    cmd(5'h0E, 11'h0FF);
    cmd(5'h01, 11'h003);
    cmd(5'h00, 11'h000);
    chk("R10 busy/cleared", status_o, 16'h1000);
    chk("R10 filter cleared", {12'b0, rx_filter_o}, 16'h0);
    cmd(5'h01, 11'h006);               // ignored while busy
    chk("R10 cmd ignored", {13'b0, window_o}, 16'h0);
    idle(BUSY - 3);
    chk("R10 still busy", {15'b0, status_o[12]}, 16'h1);
    idle(1);
    chk("R10 busy ends", {15'b0, status_o[12]}, 16'h0);
    cmd(5'h0F, 11'h0FF);
    pulse(7'b0000001);
    idle(1);
    chk("R10 masks cleared, no irq", {15'b0, irq_o}, 16'h0);
    chk("R3 bit1 after reset", {8'b0, status_o[7:0]}, 16'h0002);
    cmd(5'h01, 11'h007);
    chk("R2 window after busy", {13'b0, window_o}, 16'h7);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_unknown();
    t_cause_vis();
    t_irq();
    t_race();
    t_filter();
    t_grst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule